// File: doc/BRIEF.md
# Deferred Floating-Point Trap Queue Drain Sequencer

This block replays floating-point operations that were held back by a deferred trap. On a start strobe it looks at the depth of the trap queue and picks one of two modes. In queued mode it reads the recorded entries one by one and hands each one, an instruction word plus the address it came from, to an execution port. It stops at the first entry that reports failure. In precise mode the queue is empty, so the block fetches the faulting instruction from the current program counter and executes only that one.

When the run ends, the block raises `done` for one cycle. In that same cycle it presents every result: the overall outcome, a cleaned status-register value with its write strobe, a queue-depth clear strobe, and, for a precise run that succeeded, the advanced PC/nPC pair with its own strobe. The execution engine, the memory system and the register file lie outside the block. The PC, nPC and status register belong to the surrounding logic. The block samples them when a run is accepted and returns the new values with strobes.

The execute request and the fetch request are valid/ready channels. A request stays asserted with stable payload until `ready` is seen high at a clock edge, and a stalled `ready` only delays the run. Responses arrive as a one-cycle `done`/`ok` pulse (execute) or `rsp_valid` pulse (fetch). They may come any number of cycles later, and the sequencer waits for them.

Top module: `fpq_drain_seq`

## Requirements
- R1: After a synchronous active-high reset, `done`, `ex_valid`, `fetch_valid`, `pc_upd`, `fsr_wr` and `q_depth_clr` are all 0 and the block is idle.
- R2: A start with `q_depth` = 0 runs precise mode. It issues one fetch request with `fetch_addr` equal to the sampled `pc_in`, then one execute request carrying the fetched word, with `ex_addr` equal to that PC.
- R3: A precise run that succeeds pulses `pc_upd` with `pc_new` = old nPC and `npc_new` = old nPC + 4. If the run fails, or the fetch returns `fetch_rsp_err`, `pc_upd` stays 0 and `ok` is 0. A fetch error causes no execute request.
- R4: A start with `q_depth` > 0 issues queue entries strictly in index order 0 to depth-1. Each request carries `q_rd_instr` and `q_rd_addr` for the index presented on `q_rd_idx`.
- R5: A queued run issues nothing after the first entry that returns `ex_ok` = 0.
- R6: At the end of a queued run, `fsr_wr` pulses. `fsr_new` is the sampled `fsr_in` with bits 13:12 cleared, and bits 4:0 are also cleared only when every issued entry succeeded. A precise run never pulses `fsr_wr`.
- R7: `q_depth_clr` pulses at the end of every queued run, whatever the outcome. It never pulses in precise mode.
- R8: `ok` during the `done` cycle equals the `ex_ok` of the last issued operation (0 after a fetch error).
- R9: While `ex_valid` is high and `ex_ready` is low, `ex_valid`, `ex_instr` and `ex_addr` hold steady. The sequencer waits for `ex_done` whatever its latency.
- R10: A `q_depth` above 16 is treated as 16.
- R11: `done` is a one-cycle pulse. A start strobe that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a drain run (taken only when idle) |
| q_depth | input | 5 | Number of valid queue entries |
| q_rd_idx | output | 4 | Queue entry index being read |
| q_rd_instr | input | 32 | Instruction word of the indexed entry |
| q_rd_addr | input | 32 | Address of the indexed entry |
| q_depth_clr | output | 1 | Pulse: reset the queue depth to zero |
| pc_in | input | 32 | Current PC |
| npc_in | input | 32 | Current nPC |
| fsr_in | input | 32 | Current status register value |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | 32 | Fetch address |
| fetch_rsp_valid | input | 1 | Fetch response pulse |
| fetch_rsp_data | input | 32 | Fetched instruction word |
| fetch_rsp_err | input | 1 | Fetch failed |
| ex_valid | output | 1 | Execute request valid |
| ex_ready | input | 1 | Execute request accepted |
| ex_instr | output | 32 | Instruction to execute |
| ex_addr | output | 32 | Address of that instruction |
| ex_done | input | 1 | Execute response pulse |
| ex_ok | input | 1 | Execute succeeded (with ex_done) |
| pc_upd | output | 1 | Pulse: load pc_new/npc_new |
| pc_new | output | 32 | New PC |
| npc_new | output | 32 | New nPC |
| fsr_wr | output | 1 | Pulse: load fsr_new |
| fsr_new | output | 32 | New status register value |
| done | output | 1 | Run finished (one cycle) |
| ok | output | 1 | Run outcome, valid with done |

## Verification
A start taken at a clock edge makes the first request visible right after that edge. An execute request completes at the first edge where `ex_ready` is high. A response seen at an edge either starts the next request or enters the finish cycle at that edge. All results (`ok`, `fsr_new`, `pc_new`, strobes) are valid exactly during the one `done` cycle. The bench drives inputs and model responses at falling edges. It polls `done` at falling edges and compares every result in that same half-cycle. One falling edge later it confirms that `done` and the strobes are back to 0. The issue order and payloads come from a log the execute model keeps, and they are compared against the programmed queue once the run is done.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } seq_state_t;
endpackage

// File: rtl/fpq_seq_ctrl.sv
module fpq_seq_ctrl
  import fpq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int XLEN   = 32,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] q_depth,
  output logic [IDX_W-1:0] q_rd_idx,
  input  logic [XLEN-1:0]  q_rd_instr,
  input  logic [XLEN-1:0]  q_rd_addr,
  input  logic [XLEN-1:0]  pc_snap,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [XLEN-1:0]  fetch_addr,
  input  logic             fetch_rsp_valid,
  input  logic [XLEN-1:0]  fetch_rsp_data,
  input  logic             fetch_rsp_err,
  output logic             ex_valid,
  input  logic             ex_ready,
  output logic [XLEN-1:0]  ex_instr,
  output logic [XLEN-1:0]  ex_addr,
  input  logic             ex_done,
  input  logic             ex_ok,
  output logic             accept,
  output logic             finish,
  output logic             precise,
  output logic             run_ok,
  output logic             all_ok
);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] depth_q;
  logic             precise_q;
  logic             ok_q;
  logic             any_fail_q;
  logic [XLEN-1:0]  instr_q;
  logic [CNT_W-1:0] eff_depth;
  logic             last_entry;

  // depth saturates at the queue capacity
  assign eff_depth  = (q_depth > CNT_W'(QDEPTH)) ? CNT_W'(QDEPTH) : q_depth;
  assign last_entry = (CNT_W'(idx_q) + CNT_W'(1)) == depth_q;
  assign accept     = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      depth_q    <= '0;
      precise_q  <= 1'b0;
      ok_q       <= 1'b0;
      any_fail_q <= 1'b0;
      instr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            depth_q    <= eff_depth;
            idx_q      <= '0;
            ok_q       <= 1'b0;
            any_fail_q <= 1'b0;
            precise_q  <= (eff_depth == '0);
            state_q    <= (eff_depth == '0) ? ST_FETCH : ST_ISSUE;
          end
        end
        ST_FETCH: begin
          if (fetch_ready) state_q <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (fetch_rsp_valid) begin
            if (fetch_rsp_err) begin
              ok_q       <= 1'b0;
              any_fail_q <= 1'b1;
              state_q    <= ST_FINISH;
            end else begin
              instr_q <= fetch_rsp_data;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (ex_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ex_done) begin
            ok_q <= ex_ok;
            if (!ex_ok) any_fail_q <= 1'b1;
            if (precise_q || !ex_ok || last_entry) begin
              state_q <= ST_FINISH;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign q_rd_idx    = idx_q;
  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_addr  = pc_snap;
  assign ex_valid    = (state_q == ST_ISSUE);
  assign ex_instr    = precise_q ? instr_q : q_rd_instr;
  assign ex_addr     = precise_q ? pc_snap : q_rd_addr;
  assign finish      = (state_q == ST_FINISH);
  assign precise     = precise_q;
  assign run_ok      = ok_q;
  assign all_ok      = !any_fail_q;

  // R9: a stalled request keeps its payload
  p_ex_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_instr) && $stable(ex_addr)));

  // R5: a failed response ends the run at once
  p_stop_on_fail_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && ex_done && !ex_ok) |=> (state_q == ST_FINISH));

  // R4: queued issue never passes the sampled depth
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !precise_q) |-> (CNT_W'(idx_q) < depth_q));

  // R11: finish lasts exactly one cycle
  p_finish_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  // R2: a precise run never touches the queue index
  p_precise_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && precise_q) |-> (idx_q == '0));

endmodule

// File: rtl/fpq_pc_step.sv
module fpq_pc_step #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] npc_in,
  output logic [XLEN-1:0] pc_snap,
  output logic [XLEN-1:0] pc_new,
  output logic [XLEN-1:0] npc_new
);

  logic [XLEN-1:0] npc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_snap <= '0;
      npc_q   <= '0;
    end else if (capture) begin
      pc_snap <= pc_in;
      npc_q   <= npc_in;
    end
  end

  assign pc_new  = npc_q;
  assign npc_new = npc_q + XLEN'(STEP);

endmodule

// File: rtl/fpq_fsr_clean.sv
module fpq_fsr_clean #(
  parameter int FSR_W    = 32,
  parameter int CEXC_LSB = 0,
  parameter int CEXC_W   = 5,
  parameter int CLR_LSB  = 12,
  parameter int CLR_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [FSR_W-1:0] fsr_in,
  input  logic             all_ok,
  output logic [FSR_W-1:0] fsr_new
);

  logic [FSR_W-1:0] clr_mask;
  logic [FSR_W-1:0] cexc_mask;
  logic [FSR_W-1:0] fsr_q;

  for (genvar b = 0; b < FSR_W; b++) begin : g_mask
    assign clr_mask[b]  = (b >= CLR_LSB) && (b < CLR_LSB + CLR_W);
    assign cexc_mask[b] = (b >= CEXC_LSB) && (b < CEXC_LSB + CEXC_W);
  end

  always_ff @(posedge clk) begin
    if (rst)          fsr_q <= '0;
    else if (capture) fsr_q <= fsr_in;
  end

  always_comb begin
    fsr_new = fsr_q & ~clr_mask;
    if (all_ok) fsr_new = fsr_new & ~cexc_mask;
  end

endmodule

// File: rtl/fpq_drain_seq.sv
module fpq_drain_seq #(
  parameter int QDEPTH = 16,
  parameter int XLEN   = 32,
  parameter int FSR_W  = 32,
  localparam int CNT_W = $clog2(QDEPTH + 1),
  localparam int IDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] q_depth,
  output logic [IDX_W-1:0] q_rd_idx,
  input  logic [XLEN-1:0]  q_rd_instr,
  input  logic [XLEN-1:0]  q_rd_addr,
  output logic             q_depth_clr,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  npc_in,
  input  logic [FSR_W-1:0] fsr_in,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [XLEN-1:0]  fetch_addr,
  input  logic             fetch_rsp_valid,
  input  logic [XLEN-1:0]  fetch_rsp_data,
  input  logic             fetch_rsp_err,
  output logic             ex_valid,
  input  logic             ex_ready,
  output logic [XLEN-1:0]  ex_instr,
  output logic [XLEN-1:0]  ex_addr,
  input  logic             ex_done,
  input  logic             ex_ok,
  output logic             pc_upd,
  output logic [XLEN-1:0]  pc_new,
  output logic [XLEN-1:0]  npc_new,
  output logic             fsr_wr,
  output logic [FSR_W-1:0] fsr_new,
  output logic             done,
  output logic             ok
);

  logic            accept;
  logic            finish;
  logic            precise;
  logic            run_ok;
  logic            all_ok;
  logic [XLEN-1:0] pc_snap;

  fpq_seq_ctrl #(
    .QDEPTH(QDEPTH), .XLEN(XLEN), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .q_depth(q_depth),
    .q_rd_idx(q_rd_idx), .q_rd_instr(q_rd_instr), .q_rd_addr(q_rd_addr),
    .pc_snap(pc_snap),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
    .fetch_rsp_err(fetch_rsp_err),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_instr(ex_instr), .ex_addr(ex_addr),
    .ex_done(ex_done), .ex_ok(ex_ok),
    .accept(accept), .finish(finish), .precise(precise),
    .run_ok(run_ok), .all_ok(all_ok)
  );

  fpq_pc_step #(.XLEN(XLEN), .STEP(4)) u_pc (
    .clk(clk), .rst(rst), .capture(accept),
    .pc_in(pc_in), .npc_in(npc_in),
    .pc_snap(pc_snap), .pc_new(pc_new), .npc_new(npc_new)
  );

  fpq_fsr_clean #(
    .FSR_W(FSR_W), .CEXC_LSB(0), .CEXC_W(5), .CLR_LSB(12), .CLR_W(2)
  ) u_fsr (
    .clk(clk), .rst(rst), .capture(accept), .fsr_in(fsr_in),
    .all_ok(all_ok), .fsr_new(fsr_new)
  );

  assign done        = finish;
  assign ok          = run_ok;
  assign pc_upd      = finish && precise && run_ok;
  assign fsr_wr      = finish && !precise;
  assign q_depth_clr = finish && !precise;

  // R7: the queue clear only accompanies the end of a queued run
  p_clr_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    q_depth_clr |-> (done && !pc_upd));

  // R3: the PC is only advanced alongside a successful outcome
  p_pc_needs_ok_r3: assert property (@(posedge clk) disable iff (rst)
    pc_upd |-> (done && ok && !fsr_wr));

endmodule

// File: tb/fpq_drain_seq_tb.sv
module fpq_drain_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  q_depth = '0;
  logic [3:0]  q_rd_idx;
  logic [31:0] q_rd_instr, q_rd_addr;
  logic        q_depth_clr;
  logic [31:0] pc_in = '0, npc_in = '0, fsr_in = '0;
  logic        fetch_valid, fetch_ready;
  logic [31:0] fetch_addr;
  logic        fetch_rsp_valid, fetch_rsp_err;
  logic [31:0] fetch_rsp_data;
  logic        ex_valid, ex_ready;
  logic [31:0] ex_instr, ex_addr;
  logic        ex_done, ex_ok;
  logic        pc_upd, fsr_wr, done, ok;
  logic [31:0] pc_new, npc_new, fsr_new;

  always #2.5 clk = ~clk;

  logic [31:0] qi [16];
  logic [31:0] qa [16];
  assign q_rd_instr = qi[q_rd_idx];
  assign q_rd_addr  = qa[q_rd_idx];

  fpq_drain_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .q_depth(q_depth),
    .q_rd_idx(q_rd_idx), .q_rd_instr(q_rd_instr), .q_rd_addr(q_rd_addr),
    .q_depth_clr(q_depth_clr), .pc_in(pc_in), .npc_in(npc_in), .fsr_in(fsr_in),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
    .fetch_rsp_err(fetch_rsp_err),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_instr(ex_instr), .ex_addr(ex_addr),
    .ex_done(ex_done), .ex_ok(ex_ok),
    .pc_upd(pc_upd), .pc_new(pc_new), .npc_new(npc_new),
    .fsr_wr(fsr_wr), .fsr_new(fsr_new), .done(done), .ok(ok)
  );

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  // model configuration
  int lat = 0, fail_at = -1, stall = 0;
  logic [31:0] fetch_word = '0;
  logic        fetch_err = 1'b0;
  // logs
  int n_iss = 0, n_fetch = 0, n_done = 0;
  logic [31:0] log_i [32];
  logic [31:0] log_a [32];
  logic [31:0] log_f;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // execute responder
  initial begin
    int pend;
    pend = 0; ex_done = 0; ex_ok = 0; ex_ready = 1;
    forever begin
      @(negedge clk);
      ex_done = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ex_done = 1;
          ex_ok   = (n_iss - 1 != fail_at);
        end
      end
      ex_ready = stall ? ~ex_ready : 1'b1;
      if (ex_valid && ex_ready && pend == 0 && !ex_done) begin
        if (n_iss < 32) begin
          log_i[n_iss] = ex_instr;
          log_a[n_iss] = ex_addr;
        end
        n_iss++;
        pend = lat + 1;
      end
    end
  end

  // fetch responder
  initial begin
    bit fp;
    fp = 0; fetch_rsp_valid = 0; fetch_rsp_err = 0; fetch_rsp_data = '0; fetch_ready = 1;
    forever begin
      @(negedge clk);
      fetch_rsp_valid = 0;
      if (fp) begin
        fetch_rsp_valid = 1;
        fetch_rsp_data  = fetch_word;
        fetch_rsp_err   = fetch_err;
        fp = 0;
      end
      if (fetch_valid && fetch_ready) begin
        log_f = fetch_addr;
        n_fetch++;
        fp = 1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) n_done++;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic fill_queue(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) begin
      qi[i] = seed ^ (32'h0101_0000 * (i + 1));
      qa[i] = 32'h4000_0000 + 32'(i) * 4;
    end
  endtask

  task automatic run(input logic [4:0] depth, input logic [31:0] fsr,
                     input logic [31:0] pc, input logic [31:0] npc);
    int t;
    q_depth = depth; fsr_in = fsr; pc_in = pc; npc_in = npc;
    n_iss = 0; n_fetch = 0; n_done = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL run: actual no done expected done");
    end
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    check(req, "done low after pulse", {31'b0, done}, 32'h0);
    check(req, "strobes low after pulse", {29'b0, pc_upd, fsr_wr, q_depth_clr}, 32'h0);
  endtask

  task automatic check_order(input string req, input int n);
    check(req, "issue count", 32'(n_iss), 32'(n));
    for (int i = 0; i < n && i < 32; i++) begin
      check(req, "issued instr", log_i[i], qi[i]);
      check(req, "issued addr", log_a[i], qa[i]);
    end
  endtask

  task automatic t_reset();
    check("R1", "done", {31'b0, done}, 0);
    check("R1", "ex_valid", {31'b0, ex_valid}, 0);
    check("R1", "fetch_valid", {31'b0, fetch_valid}, 0);
    check("R1", "strobes", {29'b0, pc_upd, fsr_wr, q_depth_clr}, 0);
  endtask

  task automatic t_precise_ok();
    lat = 2; fail_at = -1; fetch_err = 0; fetch_word = 32'hABCD_0001;
    run(0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_1004);
    check("R2", "fetch count", 32'(n_fetch), 1);
    check("R2", "fetch addr", log_f, 32'h0000_1000);
    check("R2", "issue count", 32'(n_iss), 1);
    check("R2", "issued word", log_i[0], 32'hABCD_0001);
    check("R2", "issued addr", log_a[0], 32'h0000_1000);
    check("R3", "pc_upd", {31'b0, pc_upd}, 1);
    check("R3", "pc_new", pc_new, 32'h0000_1004);
    check("R3", "npc_new", npc_new, 32'h0000_1008);
    check("R8", "ok", {31'b0, ok}, 1);
    check("R6", "fsr_wr precise", {31'b0, fsr_wr}, 0);
    check("R7", "clr precise", {31'b0, q_depth_clr}, 0);
    after_done("R11");
  endtask

  task automatic t_precise_fail();
    lat = 0; fail_at = 0; fetch_err = 0; fetch_word = 32'h1234_5678;
    run(0, 32'h0, 32'h0000_2000, 32'h0000_2010);
    check("R3", "pc_upd on fail", {31'b0, pc_upd}, 0);
    check("R8", "ok on fail", {31'b0, ok}, 0);
    check("R7", "clr precise fail", {31'b0, q_depth_clr}, 0);
    after_done("R11");
  endtask

  task automatic t_fetch_err();
    lat = 0; fail_at = -1; fetch_err = 1; fetch_word = 32'h0;
    run(0, 32'h0, 32'h0000_3000, 32'h0000_3004);
    fetch_err = 0;
    check("R3", "no issue after fetch error", 32'(n_iss), 0);
    check("R3", "pc_upd fetch error", {31'b0, pc_upd}, 0);
    check("R8", "ok fetch error", {31'b0, ok}, 0);
    after_done("R11");
  endtask

  task automatic t_queue_ok();
    fill_queue(32'h8000_00A5); lat = 1; fail_at = -1;
    run(5, 32'hFFFF_FFFF, 32'h5000, 32'h5004);
    check_order("R4", 5);
    check("R6", "fsr_wr", {31'b0, fsr_wr}, 1);
    check("R6", "fsr_new all ok", fsr_new, 32'hFFFF_CFE0);
    check("R7", "clr", {31'b0, q_depth_clr}, 1);
    check("R8", "ok", {31'b0, ok}, 1);
    check("R3", "no pc_upd queued", {31'b0, pc_upd}, 0);
    after_done("R11");
  endtask

  task automatic t_queue_ok2();
    fill_queue(32'h0F0F_1234); lat = 0; fail_at = -1;
    run(1, 32'h0000_3A5F, 32'h0, 32'h4);
    check_order("R4", 1);
    check("R6", "fsr_new pattern", fsr_new, 32'h0000_0A40);
    after_done("R11");
  endtask

  task automatic t_queue_fail();
    fill_queue(32'h7777_0000); lat = 2; fail_at = 2;
    run(6, 32'hFFFF_FFFF, 32'h0, 32'h4);
    check_order("R5", 3);
    check("R6", "fsr_new on fail", fsr_new, 32'hFFFF_CFFF);
    check("R7", "clr on fail", {31'b0, q_depth_clr}, 1);
    check("R8", "ok on fail", {31'b0, ok}, 0);
    after_done("R11");
  endtask

  task automatic t_queue_last_fail();
    fill_queue(32'h2222_0000); lat = 0; fail_at = 3;
    run(4, 32'h0000_301F, 32'h0, 32'h4);
    check_order("R5", 4);
    check("R8", "ok last fails", {31'b0, ok}, 0);
    check("R6", "fsr_new last fails", fsr_new, 32'h0000_001F);
    after_done("R11");
  endtask

  task automatic t_backpressure();
    fill_queue(32'h3C3C_0000); lat = 3; fail_at = -1; stall = 1;
    run(3, 32'h0, 32'h0, 32'h4);
    stall = 0;
    check_order("R9", 3);
    check("R9", "ok with stalls", {31'b0, ok}, 1);
    after_done("R11");
  endtask

  task automatic t_clamp();
    fill_queue(32'h5A5A_0000); lat = 0; fail_at = -1;
    run(5'd20, 32'h0, 32'h0, 32'h4);
    check_order("R10", 16);
    after_done("R11");
  endtask

  task automatic t_busy_start();
    fill_queue(32'h6060_0000); lat = 4; fail_at = -1;
    q_depth = 2; fsr_in = 32'hFFFF_FFFF; n_iss = 0; n_done = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    q_depth = 7; fsr_in = 32'h0;
    start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    check("R11", "issues with busy start", 32'(n_iss), 2);
    check("R11", "single done", 32'(n_done), 1);
  endtask

  initial begin
    fill_queue(32'h0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_precise_ok();
    t_precise_fail();
    t_fetch_err();
    t_queue_ok();
    t_queue_ok2();
    t_queue_fail();
    t_queue_last_fail();
    t_backpressure();
    t_clamp();
    t_busy_start();
    report();
  end

endmodule